// File: doc/BRIEF.md
# Configurable Event Edge-Detect Channel

This block is one event input channel. It chooses an A signal and a B signal, each from its own bank of four candidate lines, can invert either one, and merges them into a single combined signal. The merge is A alone, B alone, their OR, or their AND. The channel watches the combined signal for rising and falling edges. Each direction has its own enable.

Every enabled edge can update a status flag and can raise a one-clock trigger pulse on one of four trigger outputs. The flag works in one of two modes. In sticky mode it latches an event until software clears it. In level mode it tracks the level of the combined signal, rebuilt from the edges.

The candidate lines may be asynchronous, so they pass through a synchronizer before edge detection. Configuration is a single word written through a write strobe. A separate strobe clears the flag.

Top module: `evt_edge_chan`

## Requirements
- R1: Input A is the candidate line `cand_a[s]`, where s is the configuration field at bits [1:0]. Input B is `cand_b[t]`, where t is the field at bits [3:2]. Lines that are not selected have no effect on the flag or the trigger outputs.
- R2: Bit 4 set inverts A and bit 5 set inverts B before they are combined. When either bit is clear, that signal passes through unchanged.
- R3: The combine field at bits [7:6] gives the combined signal: 0 is A, 1 is B, 2 is A OR B, 3 is A AND B.
- R4: Bit 8 enables rising-edge events and bit 9 enables falling-edge events. An edge whose enable is clear is not an event.
- R5: With bit 10 clear (sticky mode), an event sets the flag. After that, no edge changes the flag until a software clear.
- R6: With bit 10 set (level mode), a rising edge sets the flag when bit 8 is set and clears it when bit 8 is clear. A falling edge sets the flag when bit 9 is set and clears it when bit 9 is clear.
- R7: Bit 11 enables trigger pulses. While it is clear, `trig_o` stays all zero.
- R8: Each event with bit 11 set produces a pulse of exactly one clock on `trig_o[k]`, where k is the field at bits [13:12]. All other trigger bits stay low.
- R9: A `flag_clr` pulse clears the flag in the same clock edge. If an event that sets the flag occurs in that same clock edge, the flag is set instead.
- R10: After reset the flag is 0, `trig_o` is 0, and the configuration is all zeros.
- R11: A change on a candidate line that is sampled at one rising clock edge shows on `flag_o` and `trig_o` after the third rising edge, and not earlier. A configuration write that is sampled at one edge takes part in edge detection at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_a | input | 4 | Candidate lines for input A (asynchronous) |
| cand_b | input | 4 | Candidate lines for input B (asynchronous) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 14 | Configuration word (field layout given in the requirements) |
| flag_clr | input | 1 | Software clear strobe for the flag |
| flag_o | output | 1 | Status flag |
| trig_o | output | 4 | One-hot trigger pulses, one bit per output unit |

## Verification
The bench builds the channel with its default parameters: four candidates per input, four trigger outputs and a two-stage synchronizer. With these values every select value, every combine mode and every output route fits in a 14-bit word, so random configuration words exercise the whole configuration space. The fixed three-edge input latency lets a bench model predict the exact cycle of each flag change and each trigger pulse. It also lets the bench drive a clear strobe into the same edge as an event, which is the collision case in R9.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;

    localparam int CAND_N     = 4;
    localparam int SEL_W      = $clog2(CAND_N);
    localparam int OUT_N      = 4;
    localparam int OSEL_W     = $clog2(OUT_N);
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        CMB_A   = 2'd0,
        CMB_B   = 2'd1,
        CMB_OR  = 2'd2,
        CMB_AND = 2'd3
    } comb_mode_e;

    typedef enum logic {
        FLAG_STICKY = 1'b0,
        FLAG_LEVEL  = 1'b1
    } flag_mode_e;

    // Packed from MSB to LSB: the bit positions form the configuration word.
    typedef struct packed {
        logic [OSEL_W-1:0] out_sel;   // [13:12]
        logic              pulse_en;  // [11]
        flag_mode_e        fmode;     // [10]
        logic              fall_en;   // [9]
        logic              rise_en;   // [8]
        comb_mode_e        cmode;     // [7:6]
        logic              inv_b;     // [5]
        logic              inv_a;     // [4]
        logic [SEL_W-1:0]  b_sel;     // [3:2]
        logic [SEL_W-1:0]  a_sel;     // [1:0]
    } chan_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);

    function automatic logic merge_ab(input logic a, input logic b, input comb_mode_e m);
        case (m)
            CMB_A:   return a;
            CMB_B:   return b;
            CMB_OR:  return a | b;
            default: return a & b;
        endcase
    endfunction

    function automatic logic [OUT_N-1:0] route_onehot(input logic [OSEL_W-1:0] sel);
        logic [OUT_N-1:0] v;
        v      = '0;
        v[sel] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/evt_combine.sv
module evt_combine
    import evt_chan_pkg::*;
(
    input  logic [CAND_N-1:0] a_lines,
    input  logic [CAND_N-1:0] b_lines,
    input  chan_cfg_t         cfg,
    output logic              a_eff,
    output logic              b_eff,
    output logic              comb
);
    always_comb begin
        a_eff = a_lines[cfg.a_sel] ^ cfg.inv_a;
        b_eff = b_lines[cfg.b_sel] ^ cfg.inv_b;
        comb  = merge_ab(a_eff, b_eff, cfg.cmode);
    end
endmodule

// File: rtl/evt_edge_flag.sv
module evt_edge_flag
    import evt_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             comb,
    input  chan_cfg_t        cfg,
    input  logic             sw_clr,
    output logic             flag_q,
    output logic [OUT_N-1:0] trig_q
);
    logic prev_q;
    logic rise, fall, set_ev, hw_clr;

    always_comb begin
        rise   = comb & ~prev_q;
        fall   = ~comb & prev_q;
        set_ev = (rise & cfg.rise_en) | (fall & cfg.fall_en);
        hw_clr = (cfg.fmode == FLAG_LEVEL) &&
                 ((rise && !cfg.rise_en) || (fall && !cfg.fall_en));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
            trig_q <= '0;
        end else begin
            prev_q <= comb;
            if (set_ev)                flag_q <= 1'b1;
            else if (hw_clr || sw_clr) flag_q <= 1'b0;
            trig_q <= (set_ev && cfg.pulse_en) ? route_onehot(cfg.out_sel) : '0;
        end
    end

    // R8
    trig_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(trig_q));

    // R7
    trig_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (|trig_q) |-> $past(cfg.pulse_en));

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(flag_q) && !$past(sw_clr) && ($past(cfg.fmode) == FLAG_STICKY)) |-> flag_q);

    // R9
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sw_clr) && !$past(set_ev)) |-> !flag_q);

    // R4
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $past(comb && !prev_q && cfg.rise_en) |-> flag_q);
endmodule

// File: rtl/evt_edge_chan.sv
module evt_edge_chan
    import evt_chan_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CAND_N-1:0] cand_a,
    input  logic [CAND_N-1:0] cand_b,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              flag_clr,
    output logic              flag_o,
    output logic [OUT_N-1:0]  trig_o
);
    localparam int SYNC_W = 2 * CAND_N;

    chan_cfg_t         cfg_q;
    logic [SYNC_W-1:0] synced;
    logic              a_eff, b_eff, comb;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= chan_cfg_t'('0);
        else if (cfg_we) cfg_q <= chan_cfg_t'(cfg_wdata);
    end

    evt_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({cand_b, cand_a}),
        .dout (synced)
    );

    evt_combine u_comb (
        .a_lines (synced[CAND_N-1:0]),
        .b_lines (synced[SYNC_W-1:CAND_N]),
        .cfg     (cfg_q),
        .a_eff   (a_eff),
        .b_eff   (b_eff),
        .comb    (comb)
    );

    evt_edge_flag u_edge (
        .clk    (clk),
        .rst    (rst),
        .comb   (comb),
        .cfg    (cfg_q),
        .sw_clr (flag_clr),
        .flag_q (flag_o),
        .trig_q (trig_o)
    );

    // R3
    comb_and_chk: assert property (@(posedge clk) disable iff (rst)
        ((cfg_q.cmode == CMB_AND) && comb) |-> (a_eff && b_eff));

    // R3
    comb_or_chk: assert property (@(posedge clk) disable iff (rst)
        ((cfg_q.cmode == CMB_OR) && !comb) |-> (!a_eff && !b_eff));
endmodule

// File: tb/tb_evt_edge_chan.sv
`timescale 1ns/1ps
module tb_evt_edge_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cand_a = '0, cand_b = '0;
    logic        cfg_we = 1'b0;
    logic [13:0] cfg_wdata = '0;
    logic        flag_clr = 1'b0;
    logic        flag_o;
    logic [3:0]  trig_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [13:0] m_cfg  = '0;
    logic        m_comb = 1'b0;
    logic        m_flag = 1'b0;

    always #4 clk = ~clk;

    evt_edge_chan dut (
        .clk(clk), .rst(rst), .cand_a(cand_a), .cand_b(cand_b),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .flag_clr(flag_clr),
        .flag_o(flag_o), .trig_o(trig_o)
    );

    function automatic logic [13:0] mk_cfg(input int as, input int bs, input bit ia, input bit ib,
                                           input int md, input bit re, input bit fe,
                                           input bit lvl, input bit pe, input int os);
        logic [13:0] w;
        w        = '0;
        w[1:0]   = 2'(as);
        w[3:2]   = 2'(bs);
        w[4]     = ia;
        w[5]     = ib;
        w[7:6]   = 2'(md);
        w[8]     = re;
        w[9]     = fe;
        w[10]    = lvl;
        w[11]    = pe;
        w[13:12] = 2'(os);
        return w;
    endfunction

    function automatic logic f_comb(input logic [13:0] c, input logic [3:0] a, input logic [3:0] b);
        logic av, bv;
        av = a[c[1:0]] ^ c[4];
        bv = b[c[3:2]] ^ c[5];
        case (c[7:6])
            2'd0:    return av;
            2'd1:    return bv;
            2'd2:    return av | bv;
            default: return av & bv;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [3:0] exp_t, input logic exp_f);
        n_cmp++;
        if (flag_o !== exp_f) begin
            n_bad++;
            $display("FAIL %s flag: actual %0b expected %0b", tag, flag_o, exp_f);
        end
        n_cmp++;
        if (trig_o !== exp_t) begin
            n_bad++;
            $display("FAIL %s trig: actual %b expected %b", tag, trig_o, exp_t);
        end
    endtask

    // Model step: combined signal moves from m_comb to nc at the evaluated edge.
    task automatic model_edge(input logic nc, input bit clr, output logic [3:0] et);
        logic r, f, re, fe, setv, hclr;
        r    = nc & ~m_comb;
        f    = ~nc & m_comb;
        re   = m_cfg[8];
        fe   = m_cfg[9];
        setv = (r & re) | (f & fe);
        hclr = m_cfg[10] & ((r & ~re) | (f & ~fe));
        if (setv)             m_flag = 1'b1;
        else if (hclr || clr) m_flag = 1'b0;
        et     = (setv && m_cfg[11]) ? (4'b0001 << m_cfg[13:12]) : 4'b0000;
        m_comb = nc;
    endtask

    // Entered and left at a falling edge.
    task automatic do_inputs(input string tag, input logic [3:0] a, input logic [3:0] b, input bit clr);
        logic [3:0] et;
        logic nc;
        nc     = f_comb(m_cfg, a, b);
        cand_a = a;
        cand_b = b;
        @(posedge clk); @(negedge clk);
        chk({tag, " R11 early1"}, 4'b0, m_flag);
        @(posedge clk); @(negedge clk);
        chk({tag, " R11 early2"}, 4'b0, m_flag);
        flag_clr = clr;
        @(posedge clk); @(negedge clk);
        flag_clr = 1'b0;
        model_edge(nc, clr, et);
        chk(tag, et, m_flag);
        @(posedge clk); @(negedge clk);
        chk({tag, " R8 width"}, 4'b0, m_flag);
    endtask

    task automatic do_cfg(input string tag, input logic [13:0] w, input bit clr);
        logic [3:0] et;
        logic nc;
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
        chk({tag, " R11 cfg"}, 4'b0, m_flag);
        m_cfg    = w;
        nc       = f_comb(m_cfg, cand_a, cand_b);
        flag_clr = clr;
        @(posedge clk); @(negedge clk);
        flag_clr = 1'b0;
        model_edge(nc, clr, et);
        chk(tag, et, m_flag);
        @(posedge clk); @(negedge clk);
        chk({tag, " R8 width"}, 4'b0, m_flag);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10 reset", 4'b0, 1'b0);
        // The reset configuration uses A line 0: the model state must match.
        do_inputs("R10 default cfg no event", 4'b0000, 4'b0000, 1'b0);

        // R1 / R4 / R7 / R8 / R5, sticky mode
        do_cfg("R1 cfg", mk_cfg(2, 0, 0, 0, 0, 1, 0, 0, 1, 1), 1'b0);
        do_inputs("R1 unselected line", 4'b1011, 4'b1111, 1'b0);
        do_inputs("R1 R8 selected rise", 4'b0101, 4'b0000, 1'b0);
        do_inputs("R4 R5 disabled fall", 4'b0001, 4'b0000, 1'b0);
        do_inputs("R5 rise while set", 4'b0101, 4'b0000, 1'b0);
        do_inputs("R9 clear alone", 4'b0101, 4'b0000, 1'b1);
        do_inputs("R9 clear w/ disabled fall", 4'b0001, 4'b0000, 1'b1);
        do_inputs("R9 clear with rise", 4'b0101, 4'b0000, 1'b1);

        // R6 / R2 / R7: level mode, B inverted, pulses off
        do_cfg("R6 cfg", mk_cfg(0, 3, 0, 1, 1, 0, 1, 1, 0, 3), 1'b0);
        do_inputs("R2 R6 R7 fall sets", 4'b0000, 4'b1000, 1'b0);
        do_inputs("R6 rise clears", 4'b0000, 4'b0000, 1'b0);
        do_inputs("R6 fall sets again", 4'b0000, 4'b1000, 1'b0);

        // R3 combine modes with pulses on
        do_cfg("R3 and cfg", mk_cfg(1, 1, 0, 0, 3, 1, 1, 0, 1, 2), 1'b1);
        do_inputs("R3 and half", 4'b0010, 4'b0000, 1'b0);
        do_inputs("R3 and both", 4'b0010, 4'b0010, 1'b0);
        do_cfg("R3 or cfg", mk_cfg(1, 1, 1, 0, 2, 1, 1, 1, 1, 0), 1'b0);
        do_inputs("R3 or inv a", 4'b0000, 4'b0000, 1'b0);
        do_inputs("R3 or low", 4'b0010, 4'b0000, 1'b0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 8) == 0)
                do_cfg("rand R3/R5/R6/R8", 14'($urandom), ($urandom % 4) == 0);
            else
                do_inputs("rand R1/R2/R4/R9", 4'($urandom), 4'($urandom), ($urandom % 5) == 0);
        end

        finish_run();
    end
endmodule